// File: doc/BRIEF.md
# Alternating-Bit Message Tagger and Duplicate Filter

This block guards both directions of a word-wide message link with a single alternating sequence bit held in the top bit of every message. The transmit path overwrites the top bit of each outgoing word with a bit that flips once per message it accepts, so consecutive messages always carry opposite values. The receive path compares the top bit of each incoming word against the last one it let through and discards the word when the two are equal. Such a word is a repeated or stale delivery.

Each direction is a valid/ready stream with a registered output stage. A discarded word is still taken from the upstream source, but nothing is forwarded for it, and a one-cycle pulse is raised on the drop output. A history-clear input forgets the last accepted bit, so the next word is accepted whatever its top bit is. How a sender retransmits and what the payload means are left to the surrounding system.

Top module: `seqbit_link`

## Requirements
- R1: After reset both output valids and the drop output are low, the transmit input is ready, and the transmit sequence bit starts at 0.
- R2: A transmitted word leaves with bits MSG_W-2..0 equal to those of the word that entered, in entry order.
- R3: Bit MSG_W-1 of the n-th transmitted word after reset (counting from 0) equals n modulo 2, whatever the input top bit was and however many stall cycles come in between.
- R4: A received word whose top bit differs from the last accepted top bit is forwarded unchanged, all bits included, in arrival order.
- R5: A received word whose top bit equals the last accepted top bit is consumed but not forwarded, and rx_drop is high in the cycle right after the handshake that took the word.
- R6: After reset, and after any cycle with rx_hist_clear high, the next received word is accepted for either top-bit value.
- R7: While rx_hist_clear is high, rx_in_ready is low, so no word is taken in that cycle.
- R8: On either output, a word that is valid while ready is low stays valid with unchanged data in the next cycle.
- R9: An input whose output stage is empty, or whose output stage is being drained in the same cycle, is ready (rx side: unless clear is high), so one word per cycle passes without bubbles.
- R10: rx_drop is low in every cycle that does not follow the consumption of a repeated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hist_clear | input | 1 | Forget the last accepted receive bit |
| tx_in_valid | input | 1 | Outgoing word offered |
| tx_in_ready | output | 1 | Outgoing word taken |
| tx_in_data | input | MSG_W | Outgoing word before stamping |
| tx_out_valid | output | 1 | Stamped word available |
| tx_out_ready | input | 1 | Link takes stamped word |
| tx_out_data | output | MSG_W | Stamped word |
| rx_in_valid | input | 1 | Incoming word offered |
| rx_in_ready | output | 1 | Incoming word taken |
| rx_in_data | input | MSG_W | Incoming word |
| rx_out_valid | output | 1 | Accepted word available |
| rx_out_ready | input | 1 | Consumer takes accepted word |
| rx_out_data | output | MSG_W | Accepted word |
| rx_drop | output | 1 | One-cycle pulse per discarded word |

## Verification
The bench builds the block with MSG_W set to 8, so the payload is 7 bits wide. Driving 256 consecutive words through the transmit side then covers every input value, with both top-bit values, at both sequence phases. On the receive side a pseudo-random top-bit pattern, periodic history clears and throttled ready signals produce every combination of history state, repeated or fresh bit, and full or draining output stage, each compared against an arithmetic model kept in the bench.

// File: rtl/seqbit_pkg.sv
package seqbit_pkg;
  // Receive history: seen=0 means no word accepted since reset/clear
  typedef struct packed {
    logic seen;
    logic last;
  } rx_hist_t;
endpackage

// File: rtl/seqbit_outreg.sv
module seqbit_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         load;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/seqbit_stamper.sv
module seqbit_stamper #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] raw_data,
  output logic [W-1:0] stamped_data
);
  localparam int PAY_W = W - 1;

  logic seq_q, seq_d;

  always_comb begin
    seq_d = seq_q;
    if (fire) seq_d = ~seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= 1'b0;
    else        seq_q <= seq_d;
  end

  assign stamped_data = {seq_q, raw_data[PAY_W-1:0]};
endmodule

// File: rtl/seqbit_filter.sv
module seqbit_filter
  import seqbit_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hist_clear,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         stage_ready,
  output logic         in_ready,
  output logic         fwd_valid,
  output logic         drop
);
  localparam int TOP = W - 1;

  rx_hist_t hist_q, hist_d;
  logic     drop_q, drop_d;
  logic     fire, dup;

  assign in_ready  = !hist_clear && stage_ready;
  assign fire      = in_valid && in_ready;
  assign dup       = hist_q.seen && (in_data[TOP] == hist_q.last);
  assign fwd_valid = fire && !dup;

  always_comb begin
    hist_d = hist_q;
    if (hist_clear) begin
      hist_d.seen = 1'b0;
    end else if (fire && !dup) begin
      hist_d.seen = 1'b1;
      hist_d.last = in_data[TOP];
    end
    drop_d = fire && dup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      drop_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      drop_q <= drop_d;
    end
  end

  assign drop = drop_q;
endmodule

// File: rtl/seqbit_link.sv
module seqbit_link #(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_hist_clear,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [MSG_W-1:0] tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [MSG_W-1:0] tx_out_data,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [MSG_W-1:0] rx_in_data,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [MSG_W-1:0] rx_out_data,
  output logic             rx_drop
);
  logic [MSG_W-1:0] tx_stamped;
  logic             tx_fire;
  logic             rx_stage_ready;
  logic             rx_fwd_valid;

  assign tx_fire = tx_in_valid && tx_in_ready;

  seqbit_stamper #(.W(MSG_W)) u_stamp (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (tx_fire),
    .raw_data     (tx_in_data),
    .stamped_data (tx_stamped)
  );

  seqbit_outreg #(.W(MSG_W)) u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_stamped),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data)
  );

  seqbit_filter #(.W(MSG_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .hist_clear  (rx_hist_clear),
    .in_valid    (rx_in_valid),
    .in_data     (rx_in_data),
    .stage_ready (rx_stage_ready),
    .in_ready    (rx_in_ready),
    .fwd_valid   (rx_fwd_valid),
    .drop        (rx_drop)
  );

  seqbit_outreg #(.W(MSG_W)) u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_fwd_valid),
    .in_ready  (rx_stage_ready),
    .in_data   (rx_in_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data)
  );
endmodule

// File: rtl/seqbit_link_chk.sv
module seqbit_link_chk #(
  parameter int MSG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_hist_clear,
  input logic             tx_in_valid,
  input logic             tx_in_ready,
  input logic [MSG_W-1:0] tx_in_data,
  input logic             tx_out_valid,
  input logic             tx_out_ready,
  input logic [MSG_W-1:0] tx_out_data,
  input logic             rx_in_valid,
  input logic             rx_in_ready,
  input logic [MSG_W-1:0] rx_in_data,
  input logic             rx_out_valid,
  input logic             rx_out_ready,
  input logic [MSG_W-1:0] rx_out_data,
  input logic             rx_drop
);
  // R2
  tx_payload_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready) |=>
      (tx_out_valid && tx_out_data[MSG_W-2:0] == $past(tx_in_data[MSG_W-2:0])));

  // R5
  rx_drop_xor_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready) |=> (rx_drop != rx_out_valid));

  // R6
  rx_first_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_hist_clear) && rx_in_valid && rx_in_ready) |=> !rx_drop);

  // R7
  rx_clear_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hist_clear |-> !rx_in_ready);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data)));

  // R9
  tx_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_out_valid || tx_out_ready) |-> tx_in_ready);

  // R10
  rx_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> $past(rx_in_valid && rx_in_ready));
endmodule

bind seqbit_link seqbit_link_chk #(.MSG_W(MSG_W)) u_chk (.*);

// File: tb/seqbit_link_test.sv
module seqbit_link_test;
  localparam int W = 8;
  localparam int NTX = 256;
  localparam int NRX = 240;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rx_hist_clear;
  logic         tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic [W-1:0] tx_in_data, tx_out_data;
  logic         rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready, rx_drop;
  logic [W-1:0] rx_in_data, rx_out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  seqbit_link #(.MSG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_hist_clear(rx_hist_clear),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_drop(rx_drop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q[$];
    logic [W-1:0] held;
    logic [W-1:0] expw;
    bit   hold_pend;
    int   sent, got, cyc, m;
    bit   hv, hl, b, dup, exp_drop, was_first;

    rst_n = 1'b0; rx_hist_clear = 1'b0;
    tx_in_valid = 1'b0; tx_in_data = '0; tx_out_ready = 1'b0;
    rx_in_valid = 1'b0; rx_in_data = '0; rx_out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(!tx_out_valid, "R1 tx_out_valid", tx_out_valid, 0);
    check(!rx_out_valid, "R1 rx_out_valid", rx_out_valid, 0);
    check(!rx_drop, "R1 rx_drop", rx_drop, 0);
    check(tx_in_ready, "R1 tx_in_ready", tx_in_ready, 1);

    // Transmit sweep over every 8-bit input word
    sent = 0; got = 0; cyc = 0; hold_pend = 0;
    while (got < NTX) begin
      @(negedge clk);
      tx_out_ready = (cyc % 5 != 2) && !(cyc >= 40 && cyc < 46);
      tx_in_valid  = (sent < NTX) && (cyc % 7 != 6);
      tx_in_data   = sent[W-1:0];
      #1;
      if (hold_pend) begin
        // R8: stalled word held
        check(tx_out_valid && tx_out_data == held, "R8 tx hold", tx_out_data, held);
        hold_pend = 0;
      end
      if (!tx_out_valid || tx_out_ready)
        check(tx_in_ready, "R9 tx ready", tx_in_ready, 1);
      if (tx_out_valid && !tx_out_ready) begin
        hold_pend = 1; held = tx_out_data;
      end
      if (tx_out_valid && tx_out_ready) begin
        expw = {got[0], got[W-2:0]};
        check(tx_out_data[W-2:0] == expw[W-2:0], "R2 tx payload", tx_out_data, expw);
        check(tx_out_data[W-1] == expw[W-1], "R3 tx seq bit", tx_out_data[W-1], expw[W-1]);
        got++;
      end
      if (tx_in_valid && tx_in_ready) sent++;
      cyc++;
    end
    tx_in_valid = 1'b0;

    // Receive sweep with repeats, clears and backpressure
    m = 0; cyc = 0; hv = 0; hl = 0; exp_drop = 0; was_first = 0; hold_pend = 0;
    while (m < NRX || q.size() != 0 || exp_drop) begin
      @(negedge clk);
      #1;
      if (exp_drop)
        check(rx_drop, "R5 drop pulse", rx_drop, 1);
      else if (was_first)
        check(!rx_drop, "R6 first accepted", rx_drop, 0);
      else
        check(!rx_drop, "R10 no drop", rx_drop, 0);
      exp_drop = 0; was_first = 0;
      if (hold_pend) begin
        check(rx_out_valid && rx_out_data == held, "R8 rx hold", rx_out_data, held);
        hold_pend = 0;
      end
      b = ^(m[7:0] & 8'h2D) ^ m[4];
      rx_out_ready  = (cyc % 4 != 3);
      rx_hist_clear = (cyc % 23 == 11);
      rx_in_valid   = (m < NRX) && (cyc % 6 != 5);
      rx_in_data    = {b, m[W-2:0]};
      #1;
      if (rx_hist_clear)
        check(!rx_in_ready, "R7 clear blocks", rx_in_ready, 0);
      else if (!rx_out_valid || rx_out_ready)
        check(rx_in_ready, "R9 rx ready", rx_in_ready, 1);
      if (rx_out_valid && !rx_out_ready) begin
        hold_pend = 1; held = rx_out_data;
      end
      if (rx_out_valid && rx_out_ready) begin
        expw = (q.size() != 0) ? q[0] : '0;
        check(q.size() != 0 && rx_out_data == expw, "R4 rx forward", rx_out_data, expw);
        if (q.size() != 0) void'(q.pop_front());
      end
      if (rx_in_valid && rx_in_ready) begin
        dup = hv && (b == hl);
        if (dup) exp_drop = 1;
        else begin
          was_first = !hv;
          q.push_back(rx_in_data);
          hv = 1; hl = b;
        end
        m++;
      end
      if (rx_hist_clear) hv = 0;
      cyc++;
    end
    rx_in_valid = 1'b0; rx_hist_clear = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule